// File: doc/BRIEF.md
# Per-Port Programmable Input Debouncer

This block cleans up 32 digital input lines before the rest of the chip sees them. The lines are grouped into four 8-bit ports. Each raw line first passes through a two-stage synchronizer. When filtering is active for a port, the filtered output takes a new level only after the synchronized line has held that level for four consecutive ticks of the timebase the port has selected.

The timebase is a chain of prescalers run from the 8 MHz system clock. It offers four tick periods: 1 us, 16 us, 250 us and 2 ms. With four stable ticks, these give windows of about 3-4 us, 48-64 us, 0.75-1 ms and 6-8 ms. A run input gates the whole timebase. While the run input is low, every port passes its synchronized input straight through. A port whose enable bit is low also passes straight through. Configuration arrives on plain input pins; register decoding, event detection and interrupts belong to neighbouring logic.

Top module: `port_debouncer`

## Requirements
- R1: In pass-through, a raw input change appears on `filt_o` at the third rising clock edge after it is applied, and not at the second.
- R2: A port whose bit in `port_en_i` is 0 passes its synchronized inputs straight to its byte of `filt_o` (port p owns bits 8p+7..8p).
- R3: While `timebase_run_i` is 0, every port passes through whatever `port_en_i` holds, and the timebase issues no tick on the cycle it is started.
- R4: While `rst` is high and after it is released, `filt_o` equals the synchronized raw input, even if a debounce count was in progress.
- R5: With duration code 0 (field `dur_code_i[2p+1:2p]` for port p), a changed level on an active port is not accepted within 3·DIV0 clock cycles of the raw change, and it is accepted within 4·DIV0+4 cycles.
- R6: With duration code 1, the tick period is DIV0·DIV1 cycles, and the acceptance window is 3 to 4 tick periods (+4 cycles) after the raw change.
- R7: With duration code 2, the tick period is DIV0·DIV2 cycles, and the same 3-to-4-period window applies.
- R8: With duration code 3, the tick period is DIV0·DIV2·DIV3 cycles, and the same window applies.
- R9: On an active port, a pulse shorter than three tick periods never reaches `filt_o`.
- R10: Each change of the raw level restarts the stability count, so after a bounce the window is measured from the last edge.
- R11: Each port uses its own duration code; a slow port and a fast port that see the same change accept it at their own times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | NUM_PORTS*PORT_W | Asynchronous raw input lines |
| port_en_i | input | NUM_PORTS | Per-port filter enable |
| dur_code_i | input | 2*NUM_PORTS | Per-port duration code, 2 bits per port |
| timebase_run_i | input | 1 | Global gate for the debounce timebase |
| filt_o | output | NUM_PORTS*PORT_W | Filtered input word |

## Verification
The hardest state to reach is a bit whose stability count has partly advanced and is then cut off, either by a bounce of the raw line or by a reset. The pulse length is the only way the ports offer to control the count. The stimulus therefore drives bounces and pulses with gaps shorter than three tick periods, and it asserts reset in the middle of a slow window. It then checks that acceptance is timed from the last edge, or that the filter lets the input through. The bench shrinks the prescaler ratios so that all four windows fit in a few hundred cycles.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
    localparam int unsigned NUM_CODES = 4;
    localparam int unsigned CODE_W    = 2;

    typedef enum logic [CODE_W-1:0] {
        DUR_FAST  = 2'd0,
        DUR_SHORT = 2'd1,
        DUR_LONG  = 2'd2,
        DUR_SLOW  = 2'd3
    } dur_code_e;
endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/pdb_timebase.sv
module pdb_timebase #(
    parameter int unsigned DIV0 = 8,
    parameter int unsigned DIV1 = 16,
    parameter int unsigned DIV2 = 250,
    parameter int unsigned DIV3 = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run_i,
    output logic [pdb_pkg::NUM_CODES-1:0] tick_o
);
    localparam int unsigned W0 = $clog2(DIV0);
    localparam int unsigned W1 = $clog2(DIV1);
    localparam int unsigned W2 = $clog2(DIV2);
    localparam int unsigned W3 = $clog2(DIV3);
    localparam logic [W0-1:0] TOP0 = W0'(DIV0 - 1);
    localparam logic [W1-1:0] TOP1 = W1'(DIV1 - 1);
    localparam logic [W2-1:0] TOP2 = W2'(DIV2 - 1);
    localparam logic [W3-1:0] TOP3 = W3'(DIV3 - 1);

    typedef struct packed {
        logic [W0-1:0] c0;
        logic [W1-1:0] c1;
        logic [W2-1:0] c2;
        logic [W3-1:0] c3;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic t0, t1, t2, t3;

    always_comb begin
        st_d = st_q;
        t0   = run_i && (st_q.c0 == TOP0);
        t1   = t0 && (st_q.c1 == TOP1);
        t2   = t0 && (st_q.c2 == TOP2);
        t3   = t2 && (st_q.c3 == TOP3);
        if (rst || !run_i) begin
            st_d = '0;
        end else begin
            st_d.c0 = t0 ? '0 : st_q.c0 + W0'(1);
            if (t0) begin
                st_d.c1 = t1 ? '0 : st_q.c1 + W1'(1);
                st_d.c2 = t2 ? '0 : st_q.c2 + W2'(1);
            end
            if (t2) begin
                st_d.c3 = t3 ? '0 : st_q.c3 + W3'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick_o = {t3, t2, t1, t0};
endmodule

// File: rtl/pdb_port_filter.sv
module pdb_port_filter #(
    parameter int unsigned W      = 8,
    parameter int unsigned STABLE = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  logic         active_i,
    input  logic         tick_i,
    output logic [W-1:0] filt_o
);
    localparam int unsigned CW = $clog2(STABLE);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    typedef struct packed {
        logic [W-1:0][CW-1:0] cnt;
        logic [W-1:0]         prev;
        logic [W-1:0]         filt;
    } pf_state_t;

    pf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.prev[i] = sync_i[i];
            if (rst || !active_i) begin
                st_d.filt[i] = sync_i[i];
                st_d.cnt[i]  = '0;
            end else if ((sync_i[i] != st_q.prev[i]) || (sync_i[i] == st_q.filt[i])) begin
                st_d.cnt[i] = '0;
            end else if (tick_i) begin
                if (st_q.cnt[i] == LAST) begin
                    st_d.filt[i] = sync_i[i];
                    st_d.cnt[i]  = '0;
                end else begin
                    st_d.cnt[i] = st_q.cnt[i] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign filt_o = st_q.filt;
endmodule

// File: rtl/port_debouncer.sv
module port_debouncer #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned STABLE    = 4,
    parameter int unsigned DIV0      = 8,
    parameter int unsigned DIV1      = 16,
    parameter int unsigned DIV2      = 250,
    parameter int unsigned DIV3      = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_PORTS*PORT_W-1:0]            raw_i,
    input  logic [NUM_PORTS-1:0]                   port_en_i,
    input  logic [pdb_pkg::CODE_W*NUM_PORTS-1:0]   dur_code_i,
    input  logic                                   timebase_run_i,
    output logic [NUM_PORTS*PORT_W-1:0]            filt_o
);
    localparam int unsigned TOTAL_W = NUM_PORTS * PORT_W;
    localparam int unsigned CODE_W  = pdb_pkg::CODE_W;

    logic [TOTAL_W-1:0]            sync_w;
    logic [pdb_pkg::NUM_CODES-1:0] tick_w;
    logic [NUM_PORTS-1:0]          port_tick_w;
    logic [NUM_PORTS-1:0]          active_w;

    pdb_sync #(.W(TOTAL_W)) sync_i (
        .clk  (clk),
        .din  (raw_i),
        .dout (sync_w)
    );

    pdb_timebase #(
        .DIV0 (DIV0),
        .DIV1 (DIV1),
        .DIV2 (DIV2),
        .DIV3 (DIV3)
    ) timebase_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (timebase_run_i),
        .tick_o (tick_w)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign active_w[p]    = port_en_i[p] & timebase_run_i;
        assign port_tick_w[p] = tick_w[dur_code_i[CODE_W*p +: CODE_W]];

        pdb_port_filter #(
            .W      (PORT_W),
            .STABLE (STABLE)
        ) filter_i (
            .clk      (clk),
            .rst      (rst),
            .sync_i   (sync_w[PORT_W*p +: PORT_W]),
            .active_i (active_w[p]),
            .tick_i   (port_tick_w[p]),
            .filt_o   (filt_o[PORT_W*p +: PORT_W])
        );
    end
endmodule

// File: rtl/port_debouncer_chk.sv
module port_debouncer_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          run,
    input logic [NUM_PORTS*PORT_W-1:0]   filt,
    input logic [NUM_PORTS*PORT_W-1:0]   sync_val,
    input logic [pdb_pkg::NUM_CODES-1:0] ticks,
    input logic [NUM_PORTS-1:0]          port_tick,
    input logic [NUM_PORTS-1:0]          active
);
    logic [NUM_PORTS*PORT_W-1:0] act_mask;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            act_mask[PORT_W*p +: PORT_W] = {PORT_W{active[p]}};
        end
    end

    // R2: inactive bytes follow the synchronizer one edge later
    assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (rst)
        ((filt ^ $past(sync_val)) & ~$past(act_mask)) == '0);

    // R3: a freshly started timebase does not tick on its first cycle
    assert_no_tick_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (ticks == '0));

    // R5: base tick never fires on two consecutive cycles
    assert_base_tick_isolated_R5: assert property (@(posedge clk) disable iff (rst)
        ticks[0] |=> !ticks[0]);

    // R6, R7: prescaled ticks coincide with a base tick
    assert_mid_ticks_on_base_R6: assert property (@(posedge clk) disable iff (rst)
        (ticks[1] || ticks[2]) |-> ticks[0]);

    // R8: slowest tick is a subdivision of the code-2 tick
    assert_slow_tick_chain_R8: assert property (@(posedge clk) disable iff (rst)
        ticks[3] |-> ticks[2]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R9: an active byte only moves on its selected tick
        assert_change_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
            ($past(active[p]) && (filt[PORT_W*p +: PORT_W] != $past(filt[PORT_W*p +: PORT_W])))
            |-> $past(port_tick[p]));

        // R10: an accepted value is the level that was being counted
        assert_accept_sync_level_R10: assert property (@(posedge clk) disable iff (rst)
            ($past(active[p]) && (filt[PORT_W*p +: PORT_W] != $past(filt[PORT_W*p +: PORT_W])))
            |-> (((filt[PORT_W*p +: PORT_W] ^ $past(filt[PORT_W*p +: PORT_W]))
                  & (filt[PORT_W*p +: PORT_W] ^ $past(sync_val[PORT_W*p +: PORT_W]))) == '0));
    end
endmodule

bind port_debouncer port_debouncer_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .run       (timebase_run_i),
    .filt      (filt_o),
    .sync_val  (sync_w),
    .ticks     (tick_w),
    .port_tick (port_tick_w),
    .active    (active_w)
);

// File: tb/port_debouncer_tb_top.sv
module port_debouncer_tb_top;
    localparam int unsigned NP = 4;
    localparam int unsigned PW = 8;
    localparam int unsigned D0 = 2;
    localparam int unsigned D1 = 3;
    localparam int unsigned D2 = 5;
    localparam int unsigned D3 = 2;
    localparam int P0 = D0;
    localparam int P1 = D0 * D1;
    localparam int P2 = D0 * D2;
    localparam int P3 = D0 * D2 * D3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*PW-1:0]  raw = '0;
    logic [NP-1:0]     en = '0;
    logic [2*NP-1:0]   dur = '0;
    logic              run = 1'b0;
    logic [NP*PW-1:0]  filt;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    port_debouncer #(
        .NUM_PORTS (NP), .PORT_W (PW), .STABLE (4),
        .DIV0 (D0), .DIV1 (D1), .DIV2 (D2), .DIV3 (D3)
    ) dut_i (
        .clk (clk), .rst (rst), .raw_i (raw), .port_en_i (en),
        .dur_code_i (dur), .timebase_run_i (run), .filt_o (filt)
    );

    // {run, en[3:0], raw[31:0]}; active ports keep their previous byte
    localparam logic [36:0] VEC [8] = '{
        {1'b0, 4'hF, 32'hA5A5_5A5A},
        {1'b0, 4'h0, 32'h1234_5678},
        {1'b1, 4'h0, 32'hFFFF_0000},
        {1'b1, 4'h1, 32'h0F0F_0F00},
        {1'b1, 4'h1, 32'h3C3C_3C00},
        {1'b0, 4'hF, 32'h8000_0001},
        {1'b1, 4'h6, 32'h7F00_00FE},
        {1'b1, 4'h8, 32'h7F11_2233}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic window(input string req, input logic [1:0] code, input int per);
        logic [31:0] old_v;
        logic [31:0] new_v;
        dur = {4{code}};
        en  = 4'hF;
        run = 1'b1;
        step(4);
        old_v = filt;
        new_v = ~old_v;
        raw = new_v;
        step(3 * per);
        check({req, " early"}, filt, old_v);
        step(per + 4);
        check({req, " late"}, filt, new_v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] model;
        logic [31:0] old_v;
        logic [31:0] new_v;
        logic        bad;

        // R4: reset state follows synchronized raw
        raw = 32'h00FF_00FF;
        step(5);
        check("R4 during reset", filt, 32'h00FF_00FF);
        rst = 1'b0;
        step(1);
        check("R4 after release", filt, 32'h00FF_00FF);

        // R1: pass-through latency
        raw = 32'h0000_0000;
        step(2);
        check("R1 not at edge 2", filt, 32'h00FF_00FF);
        step(1);
        check("R1 at edge 3", filt, 32'h0000_0000);

        // table: R2, R3 pass-through patterns
        model = 32'h0000_0000;
        for (int v = 0; v < 8; v++) begin
            run = VEC[v][36];
            en  = VEC[v][35:32];
            raw = VEC[v][31:0];
            for (int p = 0; p < 4; p++) begin
                if (!(run && en[p])) model[8*p +: 8] = raw[8*p +: 8];
            end
            step(4);
            check(run ? "R2 vector" : "R3 vector", filt, model);
        end

        // R5..R8: acceptance windows per code
        window("R5", 2'd0, P0);
        window("R6", 2'd1, P1);
        window("R7", 2'd2, P2);
        window("R8", 2'd3, P3);

        // R9: short pulse rejected (code 1)
        dur = {4{2'd1}};
        step(4);
        old_v = filt;
        raw = ~old_v;
        bad = 1'b0;
        for (int c = 0; c < 2 * P1 + 4 * P1 + 6; c++) begin
            if (c == 2 * P1) raw = old_v;
            step(1);
            if (filt !== old_v) bad = 1'b1;
        end
        check("R9 pulse rejected", bad ? ~old_v : old_v, old_v);

        // R10: bounce restarts count (code 0)
        dur = {4{2'd0}};
        step(4);
        old_v = filt;
        new_v = ~old_v;
        for (int b = 0; b < 4; b++) begin
            raw = (b % 2 == 0) ? new_v : old_v;
            step(3);
        end
        raw = new_v;
        step(3 * P0);
        check("R10 early after last bounce", filt, old_v);
        step(P0 + 4);
        check("R10 late after last bounce", filt, new_v);

        // R11: mixed codes per port (port 3 slow, others fast)
        dur = {2'd3, 2'd0, 2'd0, 2'd0};
        step(4);
        old_v = filt;
        new_v = ~old_v;
        raw = new_v;
        step(4 * P0 + 4);
        check("R11 fast ports done, slow port held", filt, {old_v[31:24], new_v[23:0]});
        step(4 * P3 + 4 - (4 * P0 + 4));
        check("R11 slow port done", filt, new_v);

        // R4: reset mid-count releases the pending level
        old_v = filt;
        raw = ~old_v;
        step(10);
        rst = 1'b1;
        step(2);
        check("R4 reset mid-count", filt, ~old_v);
        rst = 1'b0;
        step(1);
        check("R4 after mid-count reset", filt, ~old_v);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule